// File: doc/BRIEF.md
# Prefetching Register Wrapper for a Task Core

This block sits between a simple system bus and a task-style core such as a cipher engine or a codec. The core has three registers on its internal bus. The first is a write-only input register, and a write to it starts a task. The second is a status register, whose bit 0 reads 1 once the task is finished. The third is a read-only result register. Every internal access takes several cycles, so a plain bridge would stall each system read. The wrapper avoids this by holding its own copies of status and result. Each copy has a valid flag, and a read that finds its copy valid is answered in the same cycle.

When the system writes the input register, the wrapper passes the write on to the core and marks both copies invalid. It then runs a fill sequence on the internal bus. It reads status again and again until bit 0 is 1, and then reads the result register once. After that, both copies hold the finished task. If the system reads a copy that is not valid, the wrapper holds ready low, reads the core directly, stores the value in the copy and then answers. Two counters record how many reads were answered from a valid copy and how many had to go to the core. The internal bus carries one access at a time. An access already in flight always completes. After it, the system bus takes the next free slot ahead of the fill sequence, and the sequence then carries on.

Top module: `shw_wrap`

## Requirements
- R1: After reset, sys_ready is 1 while nothing is selected, ib_req is 0, both counters are 0 and both copies are invalid, so the first read of status (address 1) goes to the core.
- R2: A system read of address 1 (status) or address 2 (result) whose copy is valid completes with zero wait cycles, returns the copy and adds one to hit_count.
- R3: A system read of address 1 or 2 whose copy is invalid holds sys_ready low until a direct internal read completes. That is 3 wait cycles when the core acknowledges on its second cycle and the bus is free. The read returns the core's value, makes the copy valid so the next read hits, and adds one to miss_count.
- R4: A system write to address 0 (input register) becomes one internal write. sys_ready rises in the cycle the core acknowledges, and both copies become invalid, so a result read straight after the write is a miss and returns the core's current result register.
- R5: After a write to address 0, the fill sequence reads status until bit 0 is 1, then reads the result register exactly once and stops. Later reads of status and result hit and return the finished values.
- R6: A new write to address 0 restarts the fill sequence from the status poll, even if the previous task has not finished, and the copies end up holding the latest task's values.
- R7: An internal access in flight always completes first. A system access waiting on that access completes in the cycle the in-flight access ends only if that access made its copy valid, and it is then counted as a hit. Otherwise the system access takes the next free slot before the fill sequence.
- R8: Reads of addresses 0 and 3 return 0 with zero wait cycles. Writes to addresses 1, 2 and 3 complete at once and have no effect. Neither starts an internal access or changes a counter.
- R9: The internal bus carries one access at a time. ib_req, ib_addr, ib_we and ib_wdata stay constant from the rise of ib_req until the cycle in which ib_ack is seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| sys_sel | input | 1 | System access request, held until sys_ready |
| sys_wr | input | 1 | 1 = write, 0 = read |
| sys_addr | input | 2 | 0 input register, 1 status, 2 result, 3 unused |
| sys_wdata | input | DW | System write data |
| sys_rdata | output | DW | System read data, valid while sys_ready is 1 |
| sys_ready | output | 1 | Access completes at the clock edge where this is 1 |
| ib_req | output | 1 | Internal access request |
| ib_we | output | 1 | Internal access is a write |
| ib_addr | output | 2 | Internal register address (same map as the system side) |
| ib_wdata | output | DW | Internal write data |
| ib_rdata | input | DW | Internal read data, valid together with ib_ack |
| ib_ack | input | 1 | One-cycle acknowledge from the core |
| hit_count | output | CW | Reads answered from a valid copy |
| miss_count | output | CW | Reads that had to go to the core |

## Verification
The bench core acknowledges on the second edge after it first sees ib_req. An uncontended miss or input write therefore raises sys_ready exactly 3 cycles after it is presented. A hit raises sys_ready in the cycle it is presented, and a read that waits behind an in-flight fill access also completes on its third cycle. Each bus task drives at the falling edge and samples sys_ready and sys_rdata one time unit later, counting the falling edges it waits. The wait count is compared with 0 or 3. Copies are read only after enough cycles for the fill sequence of a 12-cycle task to end, and internal accesses are counted at the acknowledge edges to confirm that the result register is fetched exactly once per completed task.

// File: rtl/shw_pkg.sv
package shw_pkg;
  localparam logic [1:0] ADDR_DIN  = 2'd0;
  localparam logic [1:0] ADDR_STAT = 2'd1;
  localparam logic [1:0] ADDR_DOUT = 2'd2;

  typedef enum logic [1:0] {
    PF_IDLE  = 2'd0,
    PF_POLL  = 2'd1,
    PF_FETCH = 2'd2
  } pf_state_e;
endpackage

// File: rtl/shw_ibus_master.sv
module shw_ibus_master #(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          start_we,
  input  logic [1:0]    start_addr,
  input  logic [DW-1:0] start_wdata,
  output logic          ib_req,
  output logic          ib_we,
  output logic [1:0]    ib_addr,
  output logic [DW-1:0] ib_wdata,
  input  logic          ib_ack,
  output logic          done
);
  logic          req_q, req_d;
  logic          we_q, we_d;
  logic [1:0]    addr_q, addr_d;
  logic [DW-1:0] wdata_q, wdata_d;

  always_comb begin
    req_d   = req_q;
    we_d    = we_q;
    addr_d  = addr_q;
    wdata_d = wdata_q;
    if (req_q && ib_ack) begin
      req_d = 1'b0;
    end else if (!req_q && start) begin
      req_d   = 1'b1;
      we_d    = start_we;
      addr_d  = start_addr;
      wdata_d = start_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_q   <= 1'b0;
      we_q    <= 1'b0;
      addr_q  <= '0;
      wdata_q <= '0;
    end else begin
      req_q   <= req_d;
      we_q    <= we_d;
      addr_q  <= addr_d;
      wdata_q <= wdata_d;
    end
  end

  assign ib_req   = req_q;
  assign ib_we    = we_q;
  assign ib_addr  = addr_q;
  assign ib_wdata = wdata_q;
  assign done     = req_q & ib_ack;

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (ib_req && !ib_ack) |=> (ib_req && $stable(ib_addr) && $stable(ib_we) && $stable(ib_wdata))); // R9
endmodule

// File: rtl/shw_prefetch.sv
module shw_prefetch
  import shw_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       restart,
  input  logic       done,
  input  logic       done_flag,
  output logic       need,
  output logic [1:0] need_addr
);
  pf_state_e state_q, state_d;

  always_comb begin
    state_d   = state_q;
    need      = 1'b0;
    need_addr = ADDR_STAT;
    unique case (state_q)
      PF_POLL: begin
        need      = 1'b1;
        need_addr = ADDR_STAT;
        if (done && done_flag) state_d = PF_FETCH;
      end
      PF_FETCH: begin
        need      = 1'b1;
        need_addr = ADDR_DOUT;
        if (done) state_d = PF_IDLE;
      end
      default: state_d = PF_IDLE;
    endcase
    if (restart) state_d = PF_POLL;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= PF_IDLE;
    else        state_q <= state_d;
  end

  AST_FETCH_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == PF_FETCH && $past(state_q) == PF_POLL) |-> $past(done && done_flag)); // R5
  AST_RESTART_POLL: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> (state_q == PF_POLL)); // R6
endmodule

// File: rtl/shw_sysctl.sv
module shw_sysctl
  import shw_pkg::*;
#(
  parameter int DW = 32,
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sys_sel,
  input  logic          sys_wr,
  input  logic [1:0]    sys_addr,
  input  logic [DW-1:0] sys_wdata,
  output logic          sys_ready,
  output logic [DW-1:0] sys_rdata,
  input  logic [DW-1:0] stat_sh,
  input  logic          stat_v,
  input  logic [DW-1:0] out_sh,
  input  logic          out_v,
  input  logic          op_done,
  input  logic [DW-1:0] op_rdata,
  output logic          need,
  output logic          need_we,
  output logic [1:0]    need_addr,
  output logic [DW-1:0] need_wdata,
  output logic [CW-1:0] hit_cnt,
  output logic [CW-1:0] miss_cnt
);
  logic          rd_map, wr_din, sel_v, hit, miss;
  logic [DW-1:0] sel_sh;
  logic [CW-1:0] hit_q, hit_d, miss_q, miss_d;

  always_comb begin
    rd_map = sys_sel && !sys_wr && (sys_addr == ADDR_STAT || sys_addr == ADDR_DOUT);
    wr_din = sys_sel && sys_wr && (sys_addr == ADDR_DIN);
    sel_v  = (sys_addr == ADDR_STAT) ? stat_v  : out_v;
    sel_sh = (sys_addr == ADDR_STAT) ? stat_sh : out_sh;
    hit       = 1'b0;
    miss      = 1'b0;
    sys_ready = 1'b1;
    sys_rdata = '0;
    if (rd_map) begin
      if (sel_v) begin
        hit       = 1'b1;
        sys_rdata = sel_sh;
      end else begin
        sys_ready = op_done;
        miss      = op_done;
        sys_rdata = op_rdata;
      end
    end else if (wr_din) begin
      sys_ready = op_done;
    end
    need       = (rd_map && !sel_v) || wr_din;
    need_we    = sys_wr;
    need_addr  = sys_addr;
    need_wdata = sys_wdata;
    hit_d  = hit_q  + {{(CW-1){1'b0}}, hit};
    miss_d = miss_q + {{(CW-1){1'b0}}, miss};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hit_q  <= '0;
      miss_q <= '0;
    end else begin
      hit_q  <= hit_d;
      miss_q <= miss_d;
    end
  end

  assign hit_cnt  = hit_q;
  assign miss_cnt = miss_q;

  AST_MISS_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (miss_cnt != $past(miss_cnt)) |-> (hit_cnt == $past(hit_cnt))); // R3
endmodule

// File: rtl/shw_wrap.sv
module shw_wrap
  import shw_pkg::*;
#(
  parameter int DW = 32,
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sys_sel,
  input  logic          sys_wr,
  input  logic [1:0]    sys_addr,
  input  logic [DW-1:0] sys_wdata,
  output logic [DW-1:0] sys_rdata,
  output logic          sys_ready,
  output logic          ib_req,
  output logic          ib_we,
  output logic [1:0]    ib_addr,
  output logic [DW-1:0] ib_wdata,
  input  logic [DW-1:0] ib_rdata,
  input  logic          ib_ack,
  output logic [CW-1:0] hit_count,
  output logic [CW-1:0] miss_count
);
  logic [1:0]    rs_q;
  logic          rst_n_s;
  logic          sys_need, sys_need_we, pf_need;
  logic [1:0]    sys_need_addr, pf_addr;
  logic [DW-1:0] sys_need_wdata;
  logic          start, use_sys, start_we;
  logic [1:0]    start_addr;
  logic [DW-1:0] start_wdata;
  logic          done, sys_done, pf_done, restart;
  logic          owner_q, owner_d;
  logic [DW-1:0] stat_sh_q, stat_sh_d, out_sh_q, out_sh_d;
  logic          stat_v_q, stat_v_d, out_v_q, out_v_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_n_s = rs_q[1];

  always_comb begin
    use_sys     = sys_need;
    start       = !ib_req && (sys_need || pf_need);
    start_we    = use_sys ? sys_need_we    : 1'b0;
    start_addr  = use_sys ? sys_need_addr  : pf_addr;
    start_wdata = use_sys ? sys_need_wdata : '0;
    owner_d     = start ? use_sys : owner_q;
    sys_done    = done && owner_q;
    pf_done     = done && !owner_q;
    restart     = sys_done && ib_we;
    stat_sh_d = stat_sh_q;
    stat_v_d  = stat_v_q;
    out_sh_d  = out_sh_q;
    out_v_d   = out_v_q;
    if (done && !ib_we && ib_addr == ADDR_STAT) begin
      stat_sh_d = ib_rdata;
      stat_v_d  = 1'b1;
    end
    if (done && !ib_we && ib_addr == ADDR_DOUT) begin
      out_sh_d = ib_rdata;
      out_v_d  = 1'b1;
    end
    if (restart) begin
      stat_v_d = 1'b0;
      out_v_d  = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      owner_q   <= 1'b0;
      stat_sh_q <= '0;
      stat_v_q  <= 1'b0;
      out_sh_q  <= '0;
      out_v_q   <= 1'b0;
    end else begin
      owner_q   <= owner_d;
      stat_sh_q <= stat_sh_d;
      stat_v_q  <= stat_v_d;
      out_sh_q  <= out_sh_d;
      out_v_q   <= out_v_d;
    end
  end

  shw_ibus_master #(.DW(DW)) u_master (
    .clk(clk), .rst_n(rst_n_s),
    .start(start), .start_we(start_we), .start_addr(start_addr), .start_wdata(start_wdata),
    .ib_req(ib_req), .ib_we(ib_we), .ib_addr(ib_addr), .ib_wdata(ib_wdata),
    .ib_ack(ib_ack), .done(done)
  );

  shw_prefetch u_prefetch (
    .clk(clk), .rst_n(rst_n_s),
    .restart(restart), .done(pf_done), .done_flag(ib_rdata[0]),
    .need(pf_need), .need_addr(pf_addr)
  );

  shw_sysctl #(.DW(DW), .CW(CW)) u_sysctl (
    .clk(clk), .rst_n(rst_n_s),
    .sys_sel(sys_sel), .sys_wr(sys_wr), .sys_addr(sys_addr), .sys_wdata(sys_wdata),
    .sys_ready(sys_ready), .sys_rdata(sys_rdata),
    .stat_sh(stat_sh_q), .stat_v(stat_v_q), .out_sh(out_sh_q), .out_v(out_v_q),
    .op_done(sys_done), .op_rdata(ib_rdata),
    .need(sys_need), .need_we(sys_need_we), .need_addr(sys_need_addr),
    .need_wdata(sys_need_wdata),
    .hit_cnt(hit_count), .miss_cnt(miss_count)
  );

  AST_WR_CLEARS: assert property (@(posedge clk) disable iff (!rst_n_s)
    restart |=> (!stat_v_q && !out_v_q)); // R4
  AST_SYS_FIRST: assert property (@(posedge clk) disable iff (!rst_n_s)
    (!ib_req && sys_need) |=> (ib_req && owner_q)); // R7
  AST_HIT_DATA: assert property (@(posedge clk) disable iff (!rst_n_s)
    (sys_sel && !sys_wr && sys_addr == ADDR_STAT && stat_v_q) |-> (sys_ready && sys_rdata == stat_sh_q)); // R2
  AST_UNMAPPED: assert property (@(posedge clk) disable iff (!rst_n_s)
    (sys_sel && sys_addr == 2'd3) |-> (sys_ready && (sys_wr || sys_rdata == '0))); // R8
endmodule

// File: tb/shw_wrap_test.sv
module shw_wrap_test;
  localparam int DW   = 32;
  localparam int CW   = 16;
  localparam int PER  = 10;
  localparam int TASK = 12;
  localparam logic [DW-1:0] KEY = 32'h5A5A_F00F;

  logic          clk, rst_n;
  logic          sys_sel, sys_wr;
  logic [1:0]    sys_addr;
  logic [DW-1:0] sys_wdata, sys_rdata;
  logic          sys_ready;
  logic          ib_req, ib_we, ib_ack;
  logic [1:0]    ib_addr;
  logic [DW-1:0] ib_wdata, ib_rdata;
  logic [CW-1:0] hit_count, miss_count;

  int n_tests = 0;
  int n_fail  = 0;
  int n_acc = 0, n_stat = 0, n_dout = 0;
  int exp_hit = 0, exp_miss = 0;

  shw_wrap #(.DW(DW), .CW(CW)) uut (
    .clk(clk), .rst_n(rst_n),
    .sys_sel(sys_sel), .sys_wr(sys_wr), .sys_addr(sys_addr), .sys_wdata(sys_wdata),
    .sys_rdata(sys_rdata), .sys_ready(sys_ready),
    .ib_req(ib_req), .ib_we(ib_we), .ib_addr(ib_addr), .ib_wdata(ib_wdata),
    .ib_rdata(ib_rdata), .ib_ack(ib_ack),
    .hit_count(hit_count), .miss_count(miss_count)
  );

  initial clk = 1'b0;
  always #(PER/2) clk = ~clk;

  // Core model: acknowledges on the second edge after it sees a request
  logic [DW-1:0] c_di, c_stat, c_dout;
  int lat, tcnt;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ib_ack <= 1'b0; ib_rdata <= '0; lat <= 0; tcnt <= 0;
      c_di <= '0; c_stat <= '0; c_dout <= '0;
    end else begin
      ib_ack <= 1'b0;
      if (tcnt != 0) begin
        tcnt <= tcnt - 1;
        if (tcnt == 1) begin
          c_stat <= 32'd1;
          c_dout <= c_di ^ KEY;
        end
      end
      if (ib_req && !ib_ack) begin
        if (lat == 1) begin
          lat    <= 0;
          ib_ack <= 1'b1;
          if (ib_we) begin
            if (ib_addr == 2'd0) begin
              c_di <= ib_wdata; c_stat <= '0; tcnt <= TASK;
            end
          end else begin
            ib_rdata <= (ib_addr == 2'd1) ? c_stat : (ib_addr == 2'd2) ? c_dout : '0;
          end
        end else begin
          lat <= lat + 1;
        end
      end
    end
  end

  always @(posedge clk) begin
    if (rst_n && ib_req && ib_ack) begin
      n_acc++;
      if (!ib_we && ib_addr == 2'd1) n_stat++;
      if (!ib_we && ib_addr == 2'd2) n_dout++;
    end
  end

  task automatic chk(input string req, input string what, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic sys_read(input logic [1:0] a, output logic [DW-1:0] d, output int w);
    sys_sel = 1'b1; sys_wr = 1'b0; sys_addr = a; w = 0;
    #1;
    while (!sys_ready && w < 100) begin
      @(negedge clk); #1; w++;
    end
    d = sys_rdata;
    @(negedge clk);
    sys_sel = 1'b0;
  endtask

  task automatic sys_write(input logic [1:0] a, input logic [DW-1:0] v, output int w);
    sys_sel = 1'b1; sys_wr = 1'b1; sys_addr = a; sys_wdata = v; w = 0;
    #1;
    while (!sys_ready && w < 100) begin
      @(negedge clk); #1; w++;
    end
    @(negedge clk);
    sys_sel = 1'b0; sys_wr = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic t_reset;
    #1;
    chk("R1", "ready idle", {31'd0, sys_ready}, 32'd1);
    chk("R1", "ib_req", {31'd0, ib_req}, 32'd0);
    chk("R1", "hit_count", 32'(hit_count), 32'd0);
    chk("R1", "miss_count", 32'(miss_count), 32'd0);
  endtask

  task automatic t_cold_miss;
    logic [DW-1:0] d; int w;
    sys_read(2'd1, d, w); exp_miss++;
    chk("R1", "first status read waits", 32'(w), 32'd3);
    chk("R3", "miss data", d, 32'd0);
    chk("R3", "miss_count", 32'(miss_count), 32'(exp_miss));
    sys_read(2'd1, d, w); exp_hit++;
    chk("R3", "refill makes next read a hit, waits", 32'(w), 32'd0);
    chk("R2", "hit_count", 32'(hit_count), 32'(exp_hit));
  endtask

  task automatic t_task_flow;
    logic [DW-1:0] d; int w, s0, o0;
    s0 = n_stat; o0 = n_dout;
    sys_write(2'd0, 32'h0000_1234, w);
    chk("R4", "input write waits", 32'(w), 32'd3);
    idle(60);
    chk("R5", "result fetched once", 32'(n_dout - o0), 32'd1);
    chk("R5", "status polled more than once", 32'(n_stat - s0 > 1), 32'd1);
    sys_read(2'd1, d, w); exp_hit++;
    chk("R5", "status hit waits", 32'(w), 32'd0);
    chk("R5", "status done bit", d, 32'd1);
    sys_read(2'd2, d, w); exp_hit++;
    chk("R2", "result hit waits", 32'(w), 32'd0);
    chk("R5", "result value", d, 32'h0000_1234 ^ KEY);
    chk("R2", "hit_count after task", 32'(hit_count), 32'(exp_hit));
  endtask

  task automatic t_restart_clear;
    logic [DW-1:0] d; int w;
    sys_write(2'd0, 32'h0000_BEEF, w);
    sys_read(2'd2, d, w); exp_miss++;
    chk("R4", "result read after write waits", 32'(w), 32'd3);
    chk("R4", "result read after write gives old core value", d, 32'h0000_1234 ^ KEY);
    chk("R4", "miss_count", 32'(miss_count), 32'(exp_miss));
    idle(60);
    sys_read(2'd2, d, w); exp_hit++;
    chk("R6", "new result value", d, 32'h0000_BEEF ^ KEY);
    chk("R6", "new result hit waits", 32'(w), 32'd0);
  endtask

  task automatic t_back_to_back;
    logic [DW-1:0] d; int w, o0;
    o0 = n_dout;
    sys_write(2'd0, 32'hAAAA_0001, w);
    idle(5);
    sys_write(2'd0, 32'hBBBB_0002, w);
    idle(80);
    chk("R6", "one result fetch for two writes", 32'(n_dout - o0), 32'd1);
    sys_read(2'd2, d, w); exp_hit++;
    chk("R6", "result of latest task", d, 32'hBBBB_0002 ^ KEY);
    sys_read(2'd1, d, w); exp_hit++;
    chk("R6", "status after latest task", d, 32'd1);
  endtask

  task automatic t_contention;
    logic [DW-1:0] d; int w;
    sys_write(2'd0, 32'h0C0C_0C0C, w);
    idle(1);
    sys_read(2'd1, d, w); exp_hit++;
    chk("R7", "read behind in-flight poll waits", 32'(w), 32'd3);
    chk("R7", "read behind poll returns running status", d, 32'd0);
    chk("R7", "served by poll, hit_count", 32'(hit_count), 32'(exp_hit));
    chk("R7", "served by poll, miss_count", 32'(miss_count), 32'(exp_miss));
    idle(60);
    sys_read(2'd2, d, w); exp_hit++;
    chk("R7", "sequence resumed to result", d, 32'h0C0C_0C0C ^ KEY);
  endtask

  task automatic t_unmapped;
    logic [DW-1:0] d; int w, a0;
    a0 = n_acc;
    sys_read(2'd3, d, w);
    chk("R8", "addr 3 read data", d, 32'd0);
    chk("R8", "addr 3 read waits", 32'(w), 32'd0);
    sys_read(2'd0, d, w);
    chk("R8", "addr 0 read data", d, 32'd0);
    sys_write(2'd1, 32'h0, w);
    chk("R8", "status write waits", 32'(w), 32'd0);
    sys_write(2'd2, 32'h0, w);
    sys_write(2'd3, 32'hFFFF_FFFF, w);
    idle(4);
    chk("R8", "no internal access", 32'(n_acc - a0), 32'd0);
    sys_read(2'd1, d, w); exp_hit++;
    chk("R8", "status untouched by write", d, 32'd1);
    sys_read(2'd2, d, w); exp_hit++;
    chk("R8", "result untouched by write", d, 32'h0C0C_0C0C ^ KEY);
    chk("R8", "hit_count", 32'(hit_count), 32'(exp_hit));
    chk("R8", "miss_count", 32'(miss_count), 32'(exp_miss));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: run did not end, actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    rst_n = 1'b0; sys_sel = 1'b0; sys_wr = 1'b0; sys_addr = '0; sys_wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset;
    t_cold_miss;
    t_task_flow;
    t_restart_clear;
    t_back_to_back;
    t_contention;
    t_unmapped;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule